// File: doc/BRIEF.md
# PCM Channel and Width Adapter

This block sits between an incoming PCM sample stream and a delta-sigma modulator core. Samples arrive one channel word at a time, each with a channel tag. Every word is narrowed or widened to the 24-bit core width and then stored in a 16-word receive buffer. A frame is one word for a mono input stream and two words for a stereo input stream.

Playback does not begin when the first word arrives. The block waits until the number of buffered frames exceeds a programmable threshold. The threshold is clamped to what the buffer can hold for the configured channel count. Once started, the block hands out frames on a ready/valid pull until the buffer runs dry. It then re-arms and waits for the threshold again.

On the way out, the channel count is adapted to the output mode. A mono input can feed a stereo output, with the second channel either zeroed or copied. A stereo input can feed a single-channel output through one of three selections: channel 0, channel 1, or their average. Overflow and underflow are recorded in sticky flags that a clear strobe resets.

Top module: `pcm_chan_adapt`

## Requirements
- R1: With `cfg_wide`=0 a word is taken as 16-bit and becomes `{in_data[15:0], 8'h00}`; bits 31:16 are ignored. With `cfg_wide`=1 it becomes `in_data[31:8]`.
- R2: The buffer holds 16 words. Frames leave in arrival order. In a stereo frame, the word tagged `in_chan`=0 is channel 0; when the older word carries tag 1 and the newer carries tag 0, they are swapped.
- R3: `cfg_out_mode` 2 or 3 selects two output channels on `out_ch0`/`out_ch1`. Modes 0 (left) and 1 (right) give one channel on `out_ch0`, with `out_ch1` held at zero.
- R4: A mono input (`cfg_in_stereo`=0) with a two-channel output puts the sample on `out_ch0`. `out_ch1` is 0 when `cfg_mono_copy`=0 and equals the sample when `cfg_mono_copy`=1.
- R5: A stereo input with a single-channel output gives the following, per `cfg_mix`:
  - 0: channel 0.
  - 1: channel 1.
  - 2 or 3: the sum of the two signed samples, formed in 25 bits and arithmetically shifted right by one.
- R6: The effective threshold is `cfg_thresh`, clamped to 16/channels − 1 (15 for mono, 7 for stereo). `stream_on` rises at the clock edge after the edge at which the buffered frame count first exceeds the effective threshold.
- R7: While `stream_on` is high, `out_valid` is high whenever at least one whole frame is buffered, even below the threshold. `stream_on` falls at the clock edge after the buffer becomes empty, and the threshold must then be exceeded again.
- R8: A word offered while 16 words are held is dropped and sets `err_over`.
- R9: `out_ready` high while `out_valid` is low sets `err_under`.
- R10: `clr_err` clears both flags at the next edge; an error event in the same cycle takes precedence over the clear.
- R11: After reset the buffer is empty, `out_valid` and `stream_on` are low, and both flags are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word strobe |
| in_data | input | 32 | Input sample word |
| in_chan | input | 1 | Channel tag of the input word |
| cfg_wide | input | 1 | 0: 16-bit samples, 1: 32-bit samples |
| cfg_in_stereo | input | 1 | 0: mono input, 1: stereo input |
| cfg_out_mode | input | 2 | 0 left, 1 right, 2/3 both channels |
| cfg_mono_copy | input | 1 | Mono-to-stereo fill: 0 zero, 1 copy |
| cfg_mix | input | 2 | Stereo-to-mono: 0 ch0, 1 ch1, 2/3 average |
| cfg_thresh | input | 4 | Start threshold in frames |
| clr_err | input | 1 | Clears the sticky error flags |
| out_ready | input | 1 | Core pulls one frame |
| out_valid | output | 1 | A frame is presented |
| out_ch0 | output | 24 | First output channel |
| out_ch1 | output | 24 | Second output channel (zero in single-channel modes) |
| stream_on | output | 1 | Threshold reached, playback running |
| err_over | output | 1 | Sticky overflow flag |
| err_under | output | 1 | Sticky underflow flag |

## Verification
The assertions assume two things about the inputs. First, the configuration inputs are held steady while words are buffered. Second, a stereo stream delivers its words in complete pairs. The occupancy and start-condition properties depend on both. The bench follows these rules by changing configuration only while reset is held, and by pushing stereo words in pairs. Each scenario starts from a fresh reset, so no frame straddles two configurations.

// File: rtl/pca_pkg.sv
package pca_pkg;

    localparam int IN_W  = 32;
    localparam int SMP_W = 24;

    typedef struct packed {
        logic             tag;
        logic [SMP_W-1:0] smp;
    } slot_t;

    typedef enum logic [1:0] {
        OM_LEFT  = 2'd0,
        OM_RIGHT = 2'd1,
        OM_BOTH  = 2'd2,
        OM_BOTH2 = 2'd3
    } out_mode_e;

    typedef enum logic [1:0] {
        MX_CH0  = 2'd0,
        MX_CH1  = 2'd1,
        MX_AVG  = 2'd2,
        MX_AVG2 = 2'd3
    } mix_e;

    function automatic logic [SMP_W-1:0] to_core_width(input logic [IN_W-1:0] d,
                                                       input logic wide);
        if (wide)
            return d[IN_W-1:IN_W-SMP_W];
        else
            return {d[15:0], {(SMP_W-16){1'b0}}};
    endfunction

    function automatic logic [SMP_W-1:0] mean2(input logic [SMP_W-1:0] a,
                                               input logic [SMP_W-1:0] b);
        logic signed [SMP_W:0] sum;
        sum = $signed({a[SMP_W-1], a}) + $signed({b[SMP_W-1], b});
        return sum[SMP_W:1];
    endfunction

endpackage

// File: rtl/pca_fifo.sv
module pca_fifo
    import pca_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  slot_t                        wr_slot,
    input  logic                         rd_en,
    input  logic                         rd_pair,
    output slot_t                        head0,
    output slot_t                        head1,
    output logic [$clog2(DEPTH+1)-1:0]   cnt,
    output logic                         full
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH+1);

    slot_t              mem [DEPTH];
    logic [PTR_W-1:0]   wp, rp;
    logic               accept;
    logic [CNT_W-1:0]   rd_n;

    assign full   = (cnt == CNT_W'(DEPTH));
    assign accept = wr_en && !full;
    assign rd_n   = rd_en ? (rd_pair ? CNT_W'(2) : CNT_W'(1)) : '0;
    assign head0  = mem[rp];
    assign head1  = mem[rp + PTR_W'(1)];

    always_ff @(posedge clk) begin
        if (accept)
            mem[wp] <= wr_slot;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (accept)
                wp <= wp + PTR_W'(1);
            rp  <= rp + PTR_W'(rd_n);
            cnt <= cnt + CNT_W'(accept) - rd_n;
        end
    end

    a_r8_count_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(DEPTH));

    a_r8_full_holds: assert property (@(posedge clk) disable iff (rst)
        (wr_en && full && !rd_en) |=> (cnt == CNT_W'(DEPTH)));

    a_r2_no_overdraw: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> (cnt >= rd_n));

endmodule

// File: rtl/pca_level.sv
module pca_level #(
    parameter int DEPTH = 16
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [$clog2(DEPTH+1)-1:0]    cnt,
    input  logic                          stereo_in,
    input  logic [$clog2(DEPTH)-1:0]      thr_cfg,
    output logic                          run,
    output logic                          frame_avail
);
    localparam int CNT_W   = $clog2(DEPTH+1);
    localparam int TH_W    = $clog2(DEPTH);
    localparam int MAX_M   = DEPTH - 1;
    localparam int MAX_S   = DEPTH / 2 - 1;

    logic [CNT_W-1:0] frames;
    logic [CNT_W-1:0] thr_max;
    logic [CNT_W-1:0] thr_eff;

    assign frames  = stereo_in ? (cnt >> 1) : cnt;
    assign thr_max = stereo_in ? CNT_W'(MAX_S) : CNT_W'(MAX_M);
    assign thr_eff = (CNT_W'(thr_cfg) > thr_max) ? thr_max : CNT_W'(thr_cfg);
    assign frame_avail = run && (frames != '0);

    always_ff @(posedge clk) begin
        if (rst)
            run <= 1'b0;
        else if (!run && frames > thr_eff)
            run <= 1'b1;
        else if (run && cnt == '0)
            run <= 1'b0;
    end

    a_r6_start_cond: assert property (@(posedge clk) disable iff (rst)
        $rose(run) |-> $past(frames > thr_eff));

    a_r6_clamp: assert property (@(posedge clk) disable iff (rst)
        thr_eff <= (stereo_in ? CNT_W'(MAX_S) : CNT_W'(MAX_M)));

    a_r7_stop_empty: assert property (@(posedge clk) disable iff (rst)
        $fell(run) |-> $past(cnt == '0));

    localparam int UNUSED_TH = TH_W;

endmodule

// File: rtl/pca_mixer.sv
module pca_mixer
    import pca_pkg::*;
(
    input  slot_t               head0,
    input  slot_t               head1,
    input  logic                stereo_in,
    input  out_mode_e           out_mode,
    input  logic                mono_copy,
    input  mix_e                mix,
    output logic [SMP_W-1:0]    ch0,
    output logic [SMP_W-1:0]    ch1
);
    logic [SMP_W-1:0] a, b;
    logic             swap;
    logic             two_out;

    assign swap    = head0.tag && !head1.tag;
    assign two_out = (out_mode == OM_BOTH) || (out_mode == OM_BOTH2);

    always_comb begin
        a = swap ? head1.smp : head0.smp;
        b = swap ? head0.smp : head1.smp;
        ch0 = '0;
        ch1 = '0;
        if (!stereo_in) begin
            ch0 = head0.smp;
            if (two_out && mono_copy)
                ch1 = head0.smp;
        end else if (two_out) begin
            ch0 = a;
            ch1 = b;
        end else begin
            unique case (mix)
                MX_CH0:  ch0 = a;
                MX_CH1:  ch0 = b;
                default: ch0 = mean2(a, b);
            endcase
        end
    end

endmodule

// File: rtl/pcm_chan_adapt.sv
module pcm_chan_adapt
    import pca_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      in_valid,
    input  logic [31:0]               in_data,
    input  logic                      in_chan,
    input  logic                      cfg_wide,
    input  logic                      cfg_in_stereo,
    input  logic [1:0]                cfg_out_mode,
    input  logic                      cfg_mono_copy,
    input  logic [1:0]                cfg_mix,
    input  logic [$clog2(DEPTH)-1:0]  cfg_thresh,
    input  logic                      clr_err,
    input  logic                      out_ready,
    output logic                      out_valid,
    output logic [23:0]               out_ch0,
    output logic [23:0]               out_ch1,
    output logic                      stream_on,
    output logic                      err_over,
    output logic                      err_under
);
    localparam int CNT_W = $clog2(DEPTH+1);

    slot_t            wr_slot, head0, head1;
    logic [CNT_W-1:0] cnt;
    logic             full;
    logic             pop;
    logic             run;
    logic             frame_avail;

    assign wr_slot.tag = in_chan;
    assign wr_slot.smp = to_core_width(in_data, cfg_wide);
    assign pop         = out_valid && out_ready;

    pca_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (in_valid),
        .wr_slot (wr_slot),
        .rd_en   (pop),
        .rd_pair (cfg_in_stereo),
        .head0   (head0),
        .head1   (head1),
        .cnt     (cnt),
        .full    (full)
    );

    pca_level #(.DEPTH(DEPTH)) u_level (
        .clk         (clk),
        .rst         (rst),
        .cnt         (cnt),
        .stereo_in   (cfg_in_stereo),
        .thr_cfg     (cfg_thresh),
        .run         (run),
        .frame_avail (frame_avail)
    );

    pca_mixer u_mix (
        .head0     (head0),
        .head1     (head1),
        .stereo_in (cfg_in_stereo),
        .out_mode  (out_mode_e'(cfg_out_mode)),
        .mono_copy (cfg_mono_copy),
        .mix       (mix_e'(cfg_mix)),
        .ch0       (out_ch0),
        .ch1       (out_ch1)
    );

    assign out_valid = frame_avail;
    assign stream_on = run;

    always_ff @(posedge clk) begin
        if (rst) begin
            err_over  <= 1'b0;
            err_under <= 1'b0;
        end else begin
            if (in_valid && full)
                err_over <= 1'b1;
            else if (clr_err)
                err_over <= 1'b0;
            if (out_ready && !out_valid)
                err_under <= 1'b1;
            else if (clr_err)
                err_under <= 1'b0;
        end
    end

    a_r7_valid_needs_run: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> stream_on);

    a_r3_single_ch1_zero: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !cfg_out_mode[1]) |-> (out_ch1 == '0));

    a_r10_over_sticky: assert property (@(posedge clk) disable iff (rst)
        (err_over && !clr_err) |=> err_over);

    a_r10_under_sticky: assert property (@(posedge clk) disable iff (rst)
        (err_under && !clr_err) |=> err_under);

    a_r9_under_set: assert property (@(posedge clk) disable iff (rst)
        (out_ready && !out_valid) |=> err_under);

    a_r8_over_set: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cnt == CNT_W'(DEPTH)) |=> err_over);

endmodule

// File: tb/pcm_chan_adapt_test.sv
module pcm_chan_adapt_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_chan = 1'b0;
    logic        cfg_wide = 1'b0;
    logic        cfg_in_stereo = 1'b0;
    logic [1:0]  cfg_out_mode = 2'd0;
    logic        cfg_mono_copy = 1'b0;
    logic [1:0]  cfg_mix = 2'd0;
    logic [3:0]  cfg_thresh = 4'd0;
    logic        clr_err = 1'b0;
    logic        out_ready = 1'b0;
    logic        out_valid;
    logic [23:0] out_ch0, out_ch1;
    logic        stream_on, err_over, err_under;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    pcm_chan_adapt uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_chan(in_chan),
        .cfg_wide(cfg_wide), .cfg_in_stereo(cfg_in_stereo), .cfg_out_mode(cfg_out_mode),
        .cfg_mono_copy(cfg_mono_copy), .cfg_mix(cfg_mix), .cfg_thresh(cfg_thresh),
        .clr_err(clr_err), .out_ready(out_ready), .out_valid(out_valid),
        .out_ch0(out_ch0), .out_ch1(out_ch1), .stream_on(stream_on),
        .err_over(err_over), .err_under(err_under)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic restart(input logic wide, input logic st, input logic [1:0] om,
                           input logic cp, input logic [1:0] mx, input logic [3:0] th);
        @(negedge clk);
        rst = 1'b1;
        cfg_wide = wide; cfg_in_stereo = st; cfg_out_mode = om;
        cfg_mono_copy = cp; cfg_mix = mx; cfg_thresh = th;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic push(input logic [31:0] d, input logic tag);
        in_valid = 1'b1; in_data = d; in_chan = tag;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic pull(input string req, input logic [23:0] e0, input logic [23:0] e1);
        check({req, " valid"}, {31'd0, out_valid}, 32'd1);
        check({req, " ch0"}, {8'd0, out_ch0}, {8'd0, e0});
        check({req, " ch1"}, {8'd0, out_ch1}, {8'd0, e1});
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    task automatic t_reset;
        restart(0, 0, 2'd0, 0, 2'd0, 4'd0);
        check("R11 valid", {31'd0, out_valid}, 0);
        check("R11 stream_on", {31'd0, stream_on}, 0);
        check("R11 err_over", {31'd0, err_over}, 0);
        check("R11 err_under", {31'd0, err_under}, 0);
    endtask

    task automatic t_width;
        restart(0, 0, 2'd0, 0, 2'd0, 4'd0);
        push(32'hFFFF_1234, 0);
        @(negedge clk);
        pull("R1 16-bit, R3 single", 24'h123400, 24'h0);
        restart(1, 0, 2'd1, 0, 2'd0, 4'd0);
        push(32'hAABB_CCDD, 0);
        @(negedge clk);
        pull("R1 32-bit", 24'hAABBCC, 24'h0);
    endtask

    task automatic t_mono_to_stereo;
        restart(1, 0, 2'd2, 0, 2'd0, 4'd0);
        push(32'h1122_3344, 0);
        @(negedge clk);
        pull("R4 zero fill", 24'h112233, 24'h0);
        restart(1, 0, 2'd3, 1, 2'd0, 4'd0);
        push(32'h5566_7788, 0);
        @(negedge clk);
        pull("R4 copy fill", 24'h556677, 24'h556677);
    endtask

    task automatic t_stereo_pass;
        restart(1, 1, 2'd2, 0, 2'd0, 4'd0);
        push(32'h0A0B_0C00, 0);
        push(32'h0D0E_0F00, 1);
        @(negedge clk);
        pull("R2 in order", 24'h0A0B0C, 24'h0D0E0F);
        push(32'h1111_1100, 1);
        push(32'h2222_2200, 0);
        @(negedge clk);
        pull("R2 swapped tags", 24'h222222, 24'h111111);
    endtask

    task automatic t_stereo_to_mono;
        restart(1, 1, 2'd0, 0, 2'd0, 4'd0);
        push(32'h1234_5600, 0);
        push(32'h6543_2100, 1);
        @(negedge clk);
        pull("R5 ch0", 24'h123456, 24'h0);
        restart(1, 1, 2'd1, 0, 2'd1, 4'd0);
        push(32'h1234_5600, 0);
        push(32'h6543_2100, 1);
        @(negedge clk);
        pull("R5 ch1", 24'h654321, 24'h0);
        restart(1, 1, 2'd0, 0, 2'd2, 4'd0);
        push(32'hFFFF_FC00, 0);
        push(32'h0000_0100, 1);
        @(negedge clk);
        pull("R5 avg negative", 24'hFFFFFE, 24'h0);
        restart(1, 1, 2'd0, 0, 2'd3, 4'd0);
        push(32'h7FFF_FF00, 0);
        push(32'h7FFF_FF00, 1);
        @(negedge clk);
        pull("R5 avg no wrap", 24'h7FFFFF, 24'h0);
    endtask

    task automatic t_threshold_mono;
        restart(0, 0, 2'd0, 0, 2'd0, 4'd2);
        push(32'h0000_0001, 0);
        push(32'h0000_0002, 0);
        @(negedge clk);
        @(negedge clk);
        check("R6 below threshold", {31'd0, out_valid}, 0);
        push(32'h0000_0003, 0);
        check("R6 not yet on", {31'd0, stream_on}, 0);
        @(negedge clk);
        check("R6 stream_on", {31'd0, stream_on}, 1);
        pull("R7 drain 1", 24'h000100, 24'h0);
        pull("R7 drain 2", 24'h000200, 24'h0);
        pull("R7 drain 3", 24'h000300, 24'h0);
        check("R7 empty no valid", {31'd0, out_valid}, 0);
        push(32'h0000_0004, 0);
        @(negedge clk);
        @(negedge clk);
        check("R7 re-armed", {31'd0, out_valid}, 0);
        check("R7 stream_off", {31'd0, stream_on}, 0);
    endtask

    task automatic t_clamp_overflow;
        restart(1, 1, 2'd2, 0, 2'd0, 4'd15);
        for (int i = 0; i < 7; i++) begin
            push({8'(i), 24'h0}, 0);
            push({8'(i + 8'h40), 24'h0}, 1);
        end
        @(negedge clk);
        check("R6 clamp seven frames", {31'd0, out_valid}, 0);
        push({8'd7, 24'h0}, 0);
        push({8'h47, 24'h0}, 1);
        push(32'hDEAD_BEEF, 0);
        check("R8 err_over", {31'd0, err_over}, 1);
        check("R6 clamp eight frames", {31'd0, stream_on}, 1);
        for (int i = 0; i < 8; i++)
            pull("R8 data kept", {8'(i), 16'h0}, {8'(i + 8'h40), 16'h0});
        check("R9 no valid", {31'd0, out_valid}, 0);
        check("R9 no flag yet", {31'd0, err_under}, 0);
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        check("R9 err_under", {31'd0, err_under}, 1);
        clr_err = 1'b1;
        @(negedge clk);
        clr_err = 1'b0;
        check("R10 over cleared", {31'd0, err_over}, 0);
        check("R10 under cleared", {31'd0, err_under}, 0);
        clr_err = 1'b1;
        out_ready = 1'b1;
        @(negedge clk);
        clr_err = 1'b0;
        out_ready = 1'b0;
        check("R10 event beats clear", {31'd0, err_under}, 1);
    endtask

    initial begin
        t_reset();
        t_width();
        t_mono_to_stereo();
        t_stereo_pass();
        t_stereo_to_mono();
        t_threshold_mono();
        t_clamp_overflow();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule